// File: doc/BRIEF.md
# Percent Differential Characteristic Comparator

This block evaluates one protection zone of a bus differential scheme. It receives one complex phasor per bus-zone input, already ratio-matched, together with a mask that marks which inputs are connected to the zone. An evaluation strobe makes the block latch the phasors and the mask. It then forms the differential quantity, which is the complex sum of the connected phasors, and the restraining quantity, which is the largest magnitude among the connected phasors. It then decides whether the differential-versus-restraint point lies in the operate area of a percent characteristic.

The characteristic has a fixed pickup floor and a low-slope line below a lower breakpoint. Above an upper breakpoint it has a high-slope line through the origin. Between the two breakpoints a cubic polynomial, evaluated in the offset `t = R - lower breakpoint`, joins the two lines smoothly. A separate split level on the differential magnitude divides the operate area into a low region and a high region, and each region has its own flag. All magnitude comparisons are made on squared quantities. The one integer square root is used only to place the restraint on the slope and spline axis.

A five-state controller sequences the work. IDLE waits for a strobe (IDLE→GATHER on strobe). GATHER visits one input per cycle (GATHER→ROOT after the last input). ROOT produces one bit of the restraint root per cycle (ROOT→POLY after bit 0). POLY takes three Horner steps (POLY→DECIDE after the third). DECIDE registers the results and the valid pulse (DECIDE→IDLE always).

Top module: `pctdiff_cmp`

## Requirements
- R1: `diff_sq` equals (Σ re)² + (Σ im)² where the sums run over the inputs whose `conn_mask` bit k is 1; input k occupies bits [k*PW +: PW] of `ph_re`/`ph_im` as a two's-complement value.
- R2: `rest_sq` equals the largest re²+im² among the connected inputs, and 0 when no input is connected.
- R3: Neither operate flag is set unless `diff_sq` > `pickup`² (equality does not operate).
- R4: With R = floor(sqrt(`rest_sq`)) below `lo_bpnt`, the boundary is B = (`lo_slope`·R) >> 8, where slopes are unsigned with 8 fractional bits.
- R5: With R ≥ `hi_bpnt`, the boundary is B = (`hi_slope`·R) >> 8.
- R6: With `lo_bpnt` ≤ R < `hi_bpnt`, the boundary is B = floor((((c3·t + c2)·t + c1)·t + c0) / 2^24) with t = R − `lo_bpnt`, clamped to 0 when negative; operation needs `diff_sq` > B².
- R7: An operating result sets `op_high` when `diff_sq` > `split_lvl`² and `op_low` otherwise; the two flags are never set together.
- R8: `res_valid` is a one-cycle pulse exactly N_IN+PW+4 clock edges after the edge that accepted the strobe.
- R9: A strobe that arrives while an evaluation is in progress is ignored: it produces no extra result.
- R10: After reset, all outputs are 0.
- R11: Between valid pulses, `op_low`, `op_high`, `diff_sq` and `rest_sq` hold their values.
- R12: Phasors and mask are latched at the accepted strobe; later changes on those inputs do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_stb | input | 1 | Start of evaluation (accepted in IDLE only) |
| ph_re | input | N_IN*PW | Real parts, input k at [k*PW +: PW], signed |
| ph_im | input | N_IN*PW | Imaginary parts, same packing |
| conn_mask | input | N_IN | Bit k set: input k belongs to the zone |
| pickup | input | SW | Minimum differential magnitude |
| lo_bpnt | input | SW | Lower breakpoint on the restraint |
| hi_bpnt | input | SW | Upper breakpoint on the restraint |
| split_lvl | input | SW | Differential level separating low and high regions |
| lo_slope | input | SLW | Low slope, 8 fractional bits |
| hi_slope | input | SLW | High slope, 8 fractional bits |
| cub_c0 | input | CW | Cubic constant term, signed, CF fractional bits |
| cub_c1 | input | CW | Cubic linear coefficient |
| cub_c2 | input | CW | Cubic square coefficient |
| cub_c3 | input | CW | Cubic cube coefficient |
| res_valid | output | 1 | Result pulse |
| op_low | output | 1 | Operate in the low differential region |
| op_high | output | 1 | Operate in the high differential region |
| diff_sq | output | 2*SW | Squared differential magnitude |
| rest_sq | output | 2*PW | Squared restraint magnitude |

## Verification
The assertions assume that the threshold, slope and coefficient inputs stay steady from the accepted strobe until the valid pulse, because only the phasors and the mask are latched. The pickup and split checks compare against the live configuration at the pulse. The cubic coefficients are assumed to keep the Horner accumulator inside its width. The stimulus changes the configuration only between evaluations. It derives the coefficients from a smooth join of the two slope lines with breakpoints at least 200 apart, and it keeps every phasor part within ±2047 so that the sums fit their width.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_ROOT,
        ST_POLY,
        ST_DECIDE
    } pd_state_e;
endpackage

// File: rtl/pd_magsq.sv
module pd_magsq #(
    parameter int W = 12
) (
    input  logic signed [W-1:0]   re,
    input  logic signed [W-1:0]   im,
    output logic        [2*W-1:0] sq
);
    logic signed [2*W-1:0] re2;
    logic signed [2*W-1:0] im2;

    assign re2 = re * re;
    assign im2 = im * im;
    assign sq  = $unsigned(re2) + $unsigned(im2);
endmodule

// File: rtl/pd_root_step.sv
module pd_root_step #(
    parameter int PW   = 12,
    parameter int CNTW = 5
) (
    input  logic [2*PW-1:0] x,
    input  logic [PW-1:0]   cur,
    input  logic [CNTW-1:0] bit_idx,
    output logic [PW-1:0]   nxt
);
    logic [PW-1:0]   cand;
    logic [2*PW-1:0] cand_w;
    logic [2*PW-1:0] cand_sq;

    assign cand    = cur | (PW'(1) << bit_idx);
    assign cand_w  = (2*PW)'(cand);
    assign cand_sq = cand_w * cand_w;
    assign nxt     = (cand_sq <= x) ? cand : cur;
endmodule

// File: rtl/pd_horner_step.sv
module pd_horner_step #(
    parameter int AW = 56,
    parameter int TW = 15,
    parameter int CW = 40
) (
    input  logic signed [AW-1:0] acc,
    input  logic        [TW-1:0] t,
    input  logic signed [CW-1:0] coef,
    output logic signed [AW-1:0] nxt
);
    logic signed [AW-1:0] prod;

    assign prod = acc * $signed({1'b0, t});
    assign nxt  = prod + AW'(coef);
endmodule

// File: rtl/pctdiff_cmp.sv
module pctdiff_cmp
    import pd_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int PW   = 12,
    parameter int SLW  = 9,
    parameter int SFB  = 8,
    parameter int CW   = 40,
    parameter int CF   = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eval_stb,
    input  logic [N_IN*PW-1:0]       ph_re,
    input  logic [N_IN*PW-1:0]       ph_im,
    input  logic [N_IN-1:0]          conn_mask,
    input  logic [PW+$clog2(N_IN)-1:0] pickup,
    input  logic [PW+$clog2(N_IN)-1:0] lo_bpnt,
    input  logic [PW+$clog2(N_IN)-1:0] hi_bpnt,
    input  logic [PW+$clog2(N_IN)-1:0] split_lvl,
    input  logic [SLW-1:0]           lo_slope,
    input  logic [SLW-1:0]           hi_slope,
    input  logic [CW-1:0]            cub_c0,
    input  logic [CW-1:0]            cub_c1,
    input  logic [CW-1:0]            cub_c2,
    input  logic [CW-1:0]            cub_c3,
    output logic                     res_valid,
    output logic                     op_low,
    output logic                     op_high,
    output logic [2*(PW+$clog2(N_IN))-1:0] diff_sq,
    output logic [2*PW-1:0]          rest_sq
);
    localparam int SW    = PW + $clog2(N_IN);
    localparam int DSQW  = 2 * SW;
    localparam int ISQW  = 2 * PW;
    localparam int BW    = SW + 1;
    localparam int TW    = SW + 1;
    localparam int AW    = CW + SW + 2;
    localparam int IDXW  = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int MAXC  = (N_IN > PW) ? N_IN : PW;
    localparam int CNTW  = $clog2(MAXC) + 1;

    pd_state_e state, nxt_state;
    logic      in_idle;

    logic signed [PW-1:0] in_re  [N_IN];
    logic signed [PW-1:0] in_im  [N_IN];
    logic signed [PW-1:0] cap_re [N_IN];
    logic signed [PW-1:0] cap_im [N_IN];
    logic [N_IN-1:0]      cap_mask;

    logic [CNTW-1:0]      step;
    logic signed [SW-1:0] sum_re, sum_im;
    logic [ISQW-1:0]      rmax;
    logic [PW-1:0]        root, root_nxt;
    logic signed [AW-1:0] acc_q, horner_nxt;
    logic signed [CW-1:0] coef_sel;

    logic signed [PW-1:0] sel_re, sel_im;
    logic [ISQW-1:0]      sel_sq;
    logic [DSQW-1:0]      dsq;
    logic [IDXW-1:0]      idx;

    genvar gk;
    generate
        for (gk = 0; gk < N_IN; gk++) begin : g_unpack
            assign in_re[gk] = ph_re[gk*PW +: PW];
            assign in_im[gk] = ph_im[gk*PW +: PW];
        end
    endgenerate

    assign in_idle = (state == ST_IDLE);
    assign idx     = step[IDXW-1:0];
    assign sel_re  = cap_re[idx];
    assign sel_im  = cap_im[idx];

    pd_magsq #(.W(PW)) u_in_sq (.re(sel_re), .im(sel_im), .sq(sel_sq));
    pd_magsq #(.W(SW)) u_df_sq (.re(sum_re), .im(sum_im), .sq(dsq));

    pd_root_step #(.PW(PW), .CNTW(CNTW)) u_root (
        .x(rmax), .cur(root), .bit_idx(step), .nxt(root_nxt)
    );

    // Boundary geometry
    logic [SW-1:0]        root_w;
    logic                 below_lo, above_hi;
    logic [TW-1:0]        t_val;
    logic [SLW+PW-1:0]    lo_prod, hi_prod;
    logic signed [AW-1:0] cub_sh;
    logic [BW-1:0]        bnd_lo, bnd_hi, bnd_cub, bnd;
    logic [2*BW-1:0]      bnd_sq;
    logic [DSQW-1:0]      pk_sq, sp_sq;
    logic                 over_pk, over_bnd, over_sp;

    assign root_w   = SW'(root);
    assign below_lo = root_w < lo_bpnt;
    assign above_hi = root_w >= hi_bpnt;
    assign t_val    = TW'(root_w) - TW'(lo_bpnt);

    assign coef_sel = (step == CNTW'(0)) ? $signed(cub_c2) :
                      (step == CNTW'(1)) ? $signed(cub_c1) : $signed(cub_c0);

    pd_horner_step #(.AW(AW), .TW(TW), .CW(CW)) u_horner (
        .acc(acc_q), .t(t_val), .coef(coef_sel), .nxt(horner_nxt)
    );

    assign lo_prod = (SLW+PW)'(lo_slope) * (SLW+PW)'(root);
    assign hi_prod = (SLW+PW)'(hi_slope) * (SLW+PW)'(root);
    assign bnd_lo  = BW'(lo_prod >> SFB);
    assign bnd_hi  = BW'(hi_prod >> SFB);
    assign cub_sh  = acc_q >>> CF;

    always_comb begin
        if (cub_sh[AW-1])
            bnd_cub = '0;
        else if (|cub_sh[AW-2:BW])
            bnd_cub = '1;
        else
            bnd_cub = cub_sh[BW-1:0];
    end

    assign bnd    = below_lo ? bnd_lo : (above_hi ? bnd_hi : bnd_cub);
    assign bnd_sq = (2*BW)'(bnd) * (2*BW)'(bnd);
    assign pk_sq  = DSQW'(pickup) * DSQW'(pickup);
    assign sp_sq  = DSQW'(split_lvl) * DSQW'(split_lvl);
    assign over_pk  = dsq > pk_sq;
    assign over_bnd = (2*BW)'(dsq) > bnd_sq;
    assign over_sp  = dsq > sp_sq;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:   if (eval_stb) nxt_state = ST_GATHER;
            ST_GATHER: if (step == CNTW'(N_IN - 1)) nxt_state = ST_ROOT;
            ST_ROOT:   if (step == CNTW'(0)) nxt_state = ST_POLY;
            ST_POLY:   if (step == CNTW'(2)) nxt_state = ST_DECIDE;
            ST_DECIDE: nxt_state = ST_IDLE;
            default:   nxt_state = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_IN; k++) begin
                cap_re[k] <= '0;
                cap_im[k] <= '0;
            end
            cap_mask  <= '0;
            step      <= '0;
            sum_re    <= '0;
            sum_im    <= '0;
            rmax      <= '0;
            root      <= '0;
            acc_q     <= '0;
            res_valid <= 1'b0;
            op_low    <= 1'b0;
            op_high   <= 1'b0;
            diff_sq   <= '0;
            rest_sq   <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (in_idle && eval_stb) begin
                        for (int k = 0; k < N_IN; k++) begin
                            cap_re[k] <= in_re[k];
                            cap_im[k] <= in_im[k];
                        end
                        cap_mask <= conn_mask;
                        sum_re   <= '0;
                        sum_im   <= '0;
                        rmax     <= '0;
                        step     <= '0;
                    end
                end
                ST_GATHER: begin
                    if (cap_mask[idx]) begin
                        sum_re <= sum_re + SW'(sel_re);
                        sum_im <= sum_im + SW'(sel_im);
                        if (sel_sq > rmax)
                            rmax <= sel_sq;
                    end
                    if (step == CNTW'(N_IN - 1)) begin
                        step <= CNTW'(PW - 1);
                        root <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_ROOT: begin
                    root <= root_nxt;
                    if (step == CNTW'(0))
                        acc_q <= AW'($signed(cub_c3));
                    else
                        step <= step - 1'b1;
                end
                ST_POLY: begin
                    acc_q <= horner_nxt;
                    step  <= step + 1'b1;
                end
                ST_DECIDE: begin
                    res_valid <= 1'b1;
                    op_high   <= over_pk && over_bnd && over_sp;
                    op_low    <= over_pk && over_bnd && !over_sp;
                    diff_sq   <= dsq;
                    rest_sq   <= rmax;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pd_cmp_chk.sv
module pd_cmp_chk #(
    parameter int N_IN = 4,
    parameter int PW   = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         eval_stb,
    input logic                         in_idle,
    input logic [PW+$clog2(N_IN)-1:0]   pickup,
    input logic [PW+$clog2(N_IN)-1:0]   split_lvl,
    input logic                         res_valid,
    input logic                         op_low,
    input logic                         op_high,
    input logic [2*(PW+$clog2(N_IN))-1:0] diff_sq,
    input logic [2*PW-1:0]              rest_sq
);
    localparam int SW   = PW + $clog2(N_IN);
    localparam int LAT  = N_IN + PW + 4;
    localparam int LCW  = $clog2(LAT + 2) + 1;

    logic [2*SW-1:0] pk_sq, sp_sq;
    logic [LCW-1:0]  since;
    logic            armed;

    assign pk_sq = (2*SW)'(pickup) * (2*SW)'(pickup);
    assign sp_sq = (2*SW)'(split_lvl) * (2*SW)'(split_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            armed <= 1'b0;
        end else if (eval_stb && in_idle) begin
            since <= '0;
            armed <= 1'b1;
        end else if (res_valid) begin
            armed <= 1'b0;
        end else if (armed && since != '1) begin
            since <= since + 1'b1;
        end
    end

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_low && op_high));

    // R3
    pickup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_low || op_high)) |-> (diff_sq > pk_sq));

    // R7
    split_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_high) |-> (diff_sq > sp_sq));

    // R7
    split_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_low) |-> (diff_sq <= sp_sq));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (armed && since == LCW'(LAT)));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(op_low) && $stable(op_high)
                        && $stable(diff_sq) && $stable(rest_sq)));
endmodule

bind pctdiff_cmp pd_cmp_chk #(.N_IN(N_IN), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .in_idle(in_idle),
    .pickup(pickup), .split_lvl(split_lvl), .res_valid(res_valid),
    .op_low(op_low), .op_high(op_high), .diff_sq(diff_sq), .rest_sq(rest_sq)
);

// File: tb/sim_pctdiff_cmp.sv
`timescale 1ns/1ps
module sim_pctdiff_cmp;
    localparam int N   = 4;
    localparam int PW  = 12;
    localparam int SW  = 14;
    localparam int SLW = 9;
    localparam int CW  = 40;
    localparam int LAT = N + PW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eval_stb = 1'b0;
    logic [N*PW-1:0] ph_re = '0, ph_im = '0;
    logic [N-1:0] conn_mask = '0;
    logic [SW-1:0] pickup = '0, lo_bpnt = '0, hi_bpnt = '0, split_lvl = '0;
    logic [SLW-1:0] lo_slope = '0, hi_slope = '0;
    logic [CW-1:0] cub_c0 = '0, cub_c1 = '0, cub_c2 = '0, cub_c3 = '0;
    logic res_valid, op_low, op_high;
    logic [2*SW-1:0] diff_sq;
    logic [2*PW-1:0] rest_sq;

    pctdiff_cmp u0 (
        .clk(clk), .rst_n(rst_n), .eval_stb(eval_stb), .ph_re(ph_re), .ph_im(ph_im),
        .conn_mask(conn_mask), .pickup(pickup), .lo_bpnt(lo_bpnt), .hi_bpnt(hi_bpnt),
        .split_lvl(split_lvl), .lo_slope(lo_slope), .hi_slope(hi_slope),
        .cub_c0(cub_c0), .cub_c1(cub_c1), .cub_c2(cub_c2), .cub_c3(cub_c3),
        .res_valid(res_valid), .op_low(op_low), .op_high(op_high),
        .diff_sq(diff_sq), .rest_sq(rest_sq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int  tre [N];
    int  tim [N];
    bit [N-1:0] tmask;
    longint c0, c1, c2, c3;
    longint exp_dsq, exp_rsq;
    bit exp_lo, exp_hi;
    string exp_reg;
    longint got_dsq, got_rsq;
    bit got_lo, got_hi;

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic longint sx54(input longint v);
        return (v <<< 10) >>> 10;
    endfunction

    function automatic longint isqrt(input longint x);
        longint r = 0;
        for (int b = PW - 1; b >= 0; b--) begin
            longint c = r | (longint'(1) << b);
            if (c * c <= x) r = c;
        end
        return r;
    endfunction

    task automatic set_cfg(input int p, input int l, input int h, input int s,
                           input int sl, input int sh);
        real t, p0, p1, m0, m1, sc;
        pickup = SW'(p); lo_bpnt = SW'(l); hi_bpnt = SW'(h); split_lvl = SW'(s);
        lo_slope = SLW'(sl); hi_slope = SLW'(sh);
        sc = 16777216.0;
        t  = real'(h - l);
        m0 = real'(sl) / 256.0;
        m1 = real'(sh) / 256.0;
        p0 = m0 * real'(l);
        p1 = m1 * real'(h);
        c0 = longint'(p0 * sc);
        c1 = longint'(m0 * sc);
        c2 = longint'(((3.0 * (p1 - p0) / t) - 2.0 * m0 - m1) / t * sc);
        c3 = longint'(((2.0 * (p0 - p1) / t) + m0 + m1) / (t * t) * sc);
        cub_c0 = c0[CW-1:0]; cub_c1 = c1[CW-1:0];
        cub_c2 = c2[CW-1:0]; cub_c3 = c3[CW-1:0];
    endtask

    task automatic model();
        longint sr = 0, si = 0, rsq = 0, r, b, acc, t, pk, sp;
        for (int k = 0; k < N; k++) begin
            if (tmask[k]) begin
                longint m = longint'(tre[k]) * tre[k] + longint'(tim[k]) * tim[k];
                sr += tre[k];
                si += tim[k];
                if (m > rsq) rsq = m;
            end
        end
        exp_dsq = sr * sr + si * si;
        exp_rsq = rsq;
        r = isqrt(rsq);
        if (r < longint'(lo_bpnt)) begin
            b = (longint'(lo_slope) * r) >> 8;
            exp_reg = "R4";
        end else if (r >= longint'(hi_bpnt)) begin
            b = (longint'(hi_slope) * r) >> 8;
            exp_reg = "R5";
        end else begin
            t = r - longint'(lo_bpnt);
            acc = c3;
            acc = sx54(acc * t + c2);
            acc = sx54(acc * t + c1);
            acc = sx54(acc * t + c0);
            b = acc >>> 24;
            if (b < 0) b = 0;
            if (b > 32767) b = 32767;
            exp_reg = "R6";
        end
        pk = longint'(pickup) * pickup;
        sp = longint'(split_lvl) * split_lvl;
        exp_hi = (exp_dsq > pk) && (exp_dsq > b * b) && (exp_dsq > sp);
        exp_lo = (exp_dsq > pk) && (exp_dsq > b * b) && !(exp_dsq > sp);
    endtask

    task automatic drive_vec();
        for (int k = 0; k < N; k++) begin
            ph_re[k*PW +: PW] = tre[k][PW-1:0];
            ph_im[k*PW +: PW] = tim[k][PW-1:0];
        end
        conn_mask = tmask;
    endtask

    // ftag: requirement named for the flag check; empty means the region tag
    task automatic run_eval(input bit disturb, input string ftag);
        int cyc = 0, vcount = 0, first = -1;
        string ft;
        model();
        @(negedge clk);
        drive_vec();
        eval_stb = 1'b1;
        @(negedge clk);
        eval_stb = 1'b0;
        while (cyc < LAT + 4) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) begin
                eval_stb = 1'b1;
                ph_re = ~ph_re;
                ph_im = ph_im ^ {N*PW{1'b1}};
                conn_mask = ~conn_mask;
            end
            if (disturb && cyc == 4) eval_stb = 1'b0;
            if (res_valid) begin
                vcount++;
                if (vcount == 1) begin
                    first = cyc;
                    got_dsq = longint'(diff_sq);
                    got_rsq = longint'(rest_sq);
                    got_lo = op_low;
                    got_hi = op_high;
                end
            end
        end
        ft = (ftag == "") ? exp_reg : ftag;
        chk(first == LAT, "R8 latency", first, LAT);
        chk(vcount == 1, disturb ? "R9 busy strobe" : "R8 single pulse", vcount, 1);
        chk(got_dsq == exp_dsq, disturb ? "R12 diff_sq" : "R1 diff_sq", got_dsq, exp_dsq);
        chk(got_rsq == exp_rsq, disturb ? "R12 rest_sq" : "R2 rest_sq", got_rsq, exp_rsq);
        chk(got_lo == exp_lo, {ft, " op_low"}, got_lo, exp_lo);
        chk(got_hi == exp_hi, {ft, " op_high"}, got_hi, exp_hi);
        chk(longint'(diff_sq) == got_dsq && op_low == got_lo, "R11 hold",
            longint'(diff_sq), got_dsq);
    endtask

    task automatic clear_in();
        for (int k = 0; k < N; k++) begin tre[k] = 0; tim[k] = 0; end
        tmask = '0;
    endtask

    function automatic int rpart(input int a);
        int v = int'($urandom_range(2 * a, 0)) - a;
        if (v > 2047) v = 2047;
        if (v < -2047) v = -2047;
        return v;
    endfunction

    initial begin
        int amp [4] = '{50, 300, 1000, 2047};
        void'($urandom(32'd20250611));
        set_cfg(100, 600, 1800, 1500, 64, 154);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(res_valid == 1'b0 && op_low == 1'b0 && op_high == 1'b0, "R10 flags", res_valid, 0);
        chk(diff_sq == '0 && rest_sq == '0, "R10 magnitudes", longint'(diff_sq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: nothing connected, large phasors ignored
        clear_in();
        tre[0] = 2000; tim[1] = -1900; tre[3] = 1200;
        run_eval(0, "R2");
        chk(got_rsq == 0 && got_dsq == 0, "R2 empty zone", got_rsq, 0);

        // R4: single connected input, internal fault in the low region
        clear_in();
        tre[0] = 400; tim[0] = 100; tmask = 4'b0001; tre[2] = 900;
        run_eval(0, "R4");

        // R1: through fault cancels
        clear_in();
        tre[0] = 1000; tim[0] = 200; tre[1] = -1000; tim[1] = -200; tmask = 4'b0011;
        run_eval(0, "R1");
        chk(got_dsq == 0 && !got_lo && !got_hi, "R1 through fault", got_dsq, 0);

        // R3: differential exactly at pickup does not operate, one above does
        clear_in();
        tre[0] = 100; tmask = 4'b0001;
        run_eval(0, "R3");
        chk(!got_lo && !got_hi, "R3 at pickup", got_lo, 0);
        tre[0] = 101;
        run_eval(0, "R3");
        chk(got_lo, "R3 above pickup", got_lo, 1);

        // R7: differential exactly at split -> low region; one above -> high
        clear_in();
        tre[0] = 1500; tmask = 4'b0001;
        run_eval(0, "R7");
        chk(got_lo && !got_hi, "R7 at split", got_hi, 0);
        tre[0] = 1501;
        run_eval(0, "R7");
        chk(got_hi && !got_lo, "R7 above split", got_hi, 1);

        // R6: restraint exactly at lower breakpoint (t = 0), either side of c0
        clear_in();
        tre[0] = 600; tre[1] = -450; tmask = 4'b0011;
        run_eval(0, "R6");
        tre[1] = -449;
        run_eval(0, "R6");
        chk(got_lo, "R6 just above c0", got_lo, 1);

        // R5: restraint exactly at upper breakpoint uses the high slope
        clear_in();
        tre[0] = 1800; tre[1] = -1100; tmask = 4'b0011;
        run_eval(0, "R5");

        // R9 R12: busy strobe and input changes during evaluation
        clear_in();
        tre[0] = 1300; tim[0] = -700; tre[2] = 250; tmask = 4'b0101;
        run_eval(1, "");
        clear_in();
        tre[1] = -1900; tre[3] = 1200; tim[3] = 800; tmask = 4'b1010;
        run_eval(1, "");

        // random sweep with reconfiguration
        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) begin
                int l = int'($urandom_range(1200, 200));
                int h = l + int'($urandom_range(1200, 200));
                int sl = int'($urandom_range(102, 26));
                int sh = sl + int'($urandom_range(128, 20));
                set_cfg(int'($urandom_range(200, 30)), l, h,
                        int'($urandom_range(3000, 300)), sl, sh);
            end
            clear_in();
            tmask = N'($urandom);
            for (int k = 0; k < N; k++) begin
                int a = amp[$urandom_range(3, 0)];
                tre[k] = rpart(a);
                tim[k] = rpart(a);
            end
            if (n % 3 == 0) begin
                tre[1] = -tre[0] + rpart(40);
                tim[1] = -tim[0] + rpart(40);
                if (tre[1] > 2047) tre[1] = 2047;
                if (tre[1] < -2047) tre[1] = -2047;
                if (tim[1] > 2047) tim[1] = 2047;
                if (tim[1] < -2047) tim[1] = -2047;
            end
            run_eval(n % 37 == 0, "");
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule